// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Per-Character Status Queue

This block is the receive half of an asynchronous serial port. It watches a single serial input line, finds start bits, samples each bit sixteen times per bit period using a baud-rate tick supplied from outside, and assembles characters of 8 or 9 data bits. Each finished character is written, together with its framing-error bit, its overrun bit and its ninth data bit, into a small receive queue. The queue holds two entries by default, so one more character can be taken in before an overrun is recorded.

The consumer sees the oldest queued entry on a valid/ready read port. Its data byte, ninth bit, framing-error bit and overrun bit all belong to that same entry. They stay still until the entry is popped by a cycle with valid and ready both high, so status can be inspected before the data is taken. The serial line cannot be back-pressured. If the consumer holds ready low while characters keep arriving, the queue fills. Each further character is then dropped and marked as an overrun on the newest stored entry. A compatibility input cuts the queue down to a single entry, so overrun behaviour is that of a one-register receiver. A receive-enable input qualifies start-bit detection. While it is low the line is ignored, and a line that is already low when reception is enabled is not taken as a start. Dropping the enable also abandons a frame in progress.

Top module: `uart_rx_buf`

## Requirements
- R1: After reset rd_valid_o, rd_data_o, rd_bit8_o, rd_ferr_o and rd_ovr_o are all 0.
- R2: A frame is a low start bit, data bits least significant first (8 when nine_bit_i=0, 9 when nine_bit_i=1), then a stop bit. Each bit spans 16 baud ticks, and its value is the majority of the samples taken on ticks 7, 8 and 9 of that bit, counted from 0. The ninth bit appears on rd_bit8_o, which is 0 for 8-bit frames.
- R3: A start bit is recognised only on a high-to-low transition of the synchronised line while rx_en_i=1. Frames sent while rx_en_i=0 are not received. A line that is already low when rx_en_i rises produces no character.
- R4: If the start bit samples high at its midpoint majority, the frame is discarded and nothing is queued.
- R5: A stop bit sampled low sets rd_ferr_o=1 on that character's entry. The character is still stored, and the next good frame has rd_ferr_o=0.
- R6: Entries leave the queue in arrival order, and rd_valid_o is 1 exactly while at least one unread entry is held.
- R7: An entry is popped on a rising edge where rd_valid_o=1 and rd_ready_i=1. The head fields stay unchanged until then, and rd_ready_i with rd_valid_o=0 has no effect.
- R8: A character that completes while the queue is full (and not popped in the same cycle) is dropped, and rd_ovr_o=1 is recorded on the most recently stored entry. Older entries keep rd_ovr_o=0.
- R9: With compat_i=1 the queue holds one entry, so a second character arriving before a pop is dropped and sets rd_ovr_o=1 on the held entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial receive line, idle high |
| rx_en_i | input | 1 | Receive enable, qualifies start detection |
| baud_tick_i | input | 1 | One-cycle pulse, 16 per bit period |
| nine_bit_i | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| compat_i | input | 1 | 1 limits the queue to one entry |
| rd_valid_o | output | 1 | Head entry present (receive complete) |
| rd_ready_i | input | 1 | Consumer takes the head entry |
| rd_data_o | output | DATA_W | Head entry data byte |
| rd_bit8_o | output | 1 | Head entry ninth data bit |
| rd_ferr_o | output | 1 | Head entry framing error |
| rd_ovr_o | output | 1 | Head entry overrun |

## Verification
The bench builds the block with its defaults: 8 data bits, 16 samples per bit, a two-entry queue and two synchroniser stages. The baud tick is pulsed every second clock, so a bit lasts 32 clocks. That is short enough to send every one of the 256 byte values as an 8-bit frame and a spread of 9-bit values within the run. The two-deep queue is small enough that every fill level is reached, including the full-queue overrun case, in both queue and single-buffer modes. Glitches, framing errors and a low line during disable are each driven at those widths so that the midpoint majority and the edge qualification are exercised directly.

// File: rtl/uart_rx_buf_pkg.sv
package uart_rx_buf_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd_i,
  output logic line_o,
  output logic fall_o
);
  // STAGES synchroniser flops plus one history flop for edge detection
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[STAGES-1:0], rxd_i};
  end

  assign line_o = sh_q[STAGES-1];
  assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_buf_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic              fall_i,
  input  logic              nine_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              x_o,
  output logic              ferr_o,
  output logic              busy_o
);
  localparam int unsigned CNT_W = $clog2(OVS);
  localparam int unsigned MID   = OVS / 2;
  localparam int unsigned BIT_W = $clog2(DATA_W + 1);

  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BIT_W-1:0] bit_q;
  logic [DATA_W:0]  shf_q;
  logic             s_a_q, s_b_q, nine_q;
  logic             maj;
  logic             bit_end;
  logic             at_vote;
  logic [BIT_W-1:0] last_bit;

  assign maj      = vote3(s_a_q, s_b_q, line_i);
  assign bit_end  = (cnt_q == CNT_W'(OVS - 1));
  assign at_vote  = (cnt_q == CNT_W'(MID + 1));
  assign last_bit = nine_q ? BIT_W'(DATA_W) : BIT_W'(DATA_W - 1);
  assign busy_o   = (state_q != RX_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shf_q   <= '0;
      s_a_q   <= 1'b1;
      s_b_q   <= 1'b1;
      nine_q  <= 1'b0;
      done_o  <= 1'b0;
      data_o  <= '0;
      x_o     <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!en_i) begin
        state_q <= RX_IDLE;
      end else if (state_q == RX_IDLE) begin
        if (fall_i) begin
          state_q <= RX_START;
          cnt_q   <= '0;
          bit_q   <= '0;
          nine_q  <= nine_i;
        end
      end else if (tick_i) begin
        cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
        if (cnt_q == CNT_W'(MID - 1)) s_a_q <= line_i;
        if (cnt_q == CNT_W'(MID))     s_b_q <= line_i;
        if (at_vote) begin
          unique case (state_q)
            RX_START: if (maj) state_q <= RX_IDLE;
            RX_DATA:  shf_q <= {maj, shf_q[DATA_W:1]};
            RX_STOP: begin
              done_o  <= 1'b1;
              ferr_o  <= ~maj;
              data_o  <= nine_q ? shf_q[DATA_W-1:0] : shf_q[DATA_W:1];
              x_o     <= nine_q & shf_q[DATA_W];
              state_q <= RX_IDLE;
            end
            default: ;
          endcase
        end else if (bit_end) begin
          if (state_q == RX_START) begin
            state_q <= RX_DATA;
            bit_q   <= '0;
          end else if (state_q == RX_DATA) begin
            bit_q <= bit_q + 1'b1;
            if (bit_q == last_bit) state_q <= RX_STOP;
          end
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       single_i,
  input  logic                       push_i,
  input  logic [DATA_W-1:0]          push_data_i,
  input  logic                       push_x_i,
  input  logic                       push_ferr_i,
  input  logic                       pop_req_i,
  output logic                       valid_o,
  output logic [DATA_W-1:0]          data_o,
  output logic                       x_o,
  output logic                       ferr_o,
  output logic                       ovr_o,
  output logic [$clog2(DEPTH+1)-1:0] level_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned LVL_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_d [DEPTH];
  logic [DEPTH-1:0]  mem_x, mem_f, mem_o;
  logic [PTR_W-1:0]  rd_ptr_q, wr_ptr_q, last_ptr;
  logic [LVL_W-1:0]  level_q, cap, lvl_after;
  logic              pop, accept, drop, full_eff;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign cap       = single_i ? LVL_W'(1) : LVL_W'(DEPTH);
  assign valid_o   = (level_q != '0);
  assign pop       = valid_o & pop_req_i;
  assign lvl_after = level_q - LVL_W'(pop);
  assign full_eff  = (lvl_after >= cap);
  assign accept    = push_i & ~full_eff;
  assign drop      = push_i & full_eff;
  assign last_ptr  = (wr_ptr_q == '0) ? PTR_W'(DEPTH - 1) : wr_ptr_q - 1'b1;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mem_d[i] <= '0;
          mem_x[i] <= 1'b0;
          mem_f[i] <= 1'b0;
          mem_o[i] <= 1'b0;
        end else if (accept && wr_ptr_q == PTR_W'(i)) begin
          mem_d[i] <= push_data_i;
          mem_x[i] <= push_x_i;
          mem_f[i] <= push_ferr_i;
          mem_o[i] <= 1'b0;
        end else if (drop && last_ptr == PTR_W'(i)) begin
          mem_o[i] <= 1'b1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (pop)    rd_ptr_q <= nxt(rd_ptr_q);
      if (accept) wr_ptr_q <= nxt(wr_ptr_q);
      level_q <= lvl_after + LVL_W'(accept);
    end
  end

  assign data_o  = mem_d[rd_ptr_q];
  assign x_o     = mem_x[rd_ptr_q];
  assign ferr_o  = mem_f[rd_ptr_q];
  assign ovr_o   = mem_o[rd_ptr_q];
  assign level_o = level_q;
endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned OVS         = 16,
  parameter int unsigned DEPTH       = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd_i,
  input  logic              rx_en_i,
  input  logic              baud_tick_i,
  input  logic              nine_bit_i,
  input  logic              compat_i,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_bit8_o,
  output logic              rd_ferr_o,
  output logic              rd_ovr_o
);
  localparam int unsigned LVL_W = $clog2(DEPTH + 1);

  logic              line_s, fall_s;
  logic              frm_done, frm_x, frm_ferr, frm_busy;
  logic [DATA_W-1:0] frm_data;
  logic [LVL_W-1:0]  q_level;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rxd_i  (rxd_i),
    .line_o (line_s),
    .fall_o (fall_s)
  );

  uart_rx_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (rx_en_i),
    .tick_i (baud_tick_i),
    .line_i (line_s),
    .fall_i (fall_s),
    .nine_i (nine_bit_i),
    .done_o (frm_done),
    .data_o (frm_data),
    .x_o    (frm_x),
    .ferr_o (frm_ferr),
    .busy_o (frm_busy)
  );

  uart_rx_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_queue (
    .clk         (clk),
    .rst_n       (rst_n),
    .single_i    (compat_i),
    .push_i      (frm_done),
    .push_data_i (frm_data),
    .push_x_i    (frm_x),
    .push_ferr_i (frm_ferr),
    .pop_req_i   (rd_ready_i),
    .valid_o     (rd_valid_o),
    .data_o      (rd_data_o),
    .x_o         (rd_bit8_o),
    .ferr_o      (rd_ferr_o),
    .ovr_o       (rd_ovr_o),
    .level_o     (q_level)
  );
endmodule

// File: rtl/uart_rx_buf_chk.sv
module uart_rx_buf_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rx_en,
  input logic                       compat,
  input logic                       rd_valid,
  input logic                       rd_ready,
  input logic [DATA_W-1:0]          rd_data,
  input logic                       rd_bit8,
  input logic                       rd_ferr,
  input logic                       frame_done,
  input logic                       busy,
  input logic [$clog2(DEPTH+1)-1:0] level
);
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= ($clog2(DEPTH+1))'(DEPTH));

  // R6
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && !frame_done) |=> !rd_valid);

  // R7
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_bit8) && $stable(rd_ferr)));

  // R7
  last_pop_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && level == 1 && !frame_done) |=> !rd_valid);

  // R9
  single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (compat && level == 1 && !rd_ready) |=> level == 1);

  // R3
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !busy) |=> !busy);
endmodule

bind uart_rx_buf uart_rx_buf_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_en      (rx_en_i),
  .compat     (compat_i),
  .rd_valid   (rd_valid_o),
  .rd_ready   (rd_ready_i),
  .rd_data    (rd_data_o),
  .rd_bit8    (rd_bit8_o),
  .rd_ferr    (rd_ferr_o),
  .frame_done (frm_done),
  .busy       (frm_busy),
  .level      (q_level)
);

// File: tb/uart_rx_buf_test.sv
module uart_rx_buf_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int OVS        = 16;
  localparam int BIT_CLKS   = TICK_DIV * OVS;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n, rxd, rx_en, tick, nine, compat, rd_ready;
  logic       rd_valid, rd_bit8, rd_ferr, rd_ovr;
  logic [7:0] rd_data;
  int         n_chk = 0;
  int         n_bad = 0;
  int         tdiv  = 0;
  bit         done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tdiv <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    tick <= (tdiv == 0);
  end

  uart_rx_buf uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .rxd_i       (rxd),
    .rx_en_i     (rx_en),
    .baud_tick_i (tick),
    .nine_bit_i  (nine),
    .compat_i    (compat),
    .rd_valid_o  (rd_valid),
    .rd_ready_i  (rd_ready),
    .rd_data_o   (rd_data),
    .rd_bit8_o   (rd_bit8),
    .rd_ferr_o   (rd_ferr),
    .rd_ovr_o    (rd_ovr)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic hold_line(input logic v, input int clks);
    rxd = v;
    repeat (clks) @(negedge clk);
  endtask

  task automatic send_frame(input logic [8:0] val, input bit nine_m, input logic stop_v);
    hold_line(1'b0, BIT_CLKS);
    for (int i = 0; i < (nine_m ? 9 : 8); i++) hold_line(val[i], BIT_CLKS);
    hold_line(stop_v, BIT_CLKS);
    hold_line(1'b1, BIT_CLKS);
  endtask

  task automatic pop_expect(input string req, input logic [7:0] d, input logic b8,
                            input logic fe, input logic ov);
    @(negedge clk);
    chk(req, "valid", 32'(rd_valid), 32'd1);
    chk(req, "data", 32'(rd_data), 32'(d));
    chk(req, "bit8", 32'(rd_bit8), 32'(b8));
    chk(req, "ferr", 32'(rd_ferr), 32'(fe));
    chk(req, "ovr", 32'(rd_ovr), 32'(ov));
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic expect_empty(input string req);
    @(negedge clk);
    chk(req, "valid", 32'(rd_valid), 32'd0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rxd = 1'b1; rx_en = 1'b1; nine = 1'b0;
    compat = 1'b0; rd_ready = 1'b0; tick = 1'b0;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1", "valid", 32'(rd_valid), 32'd0);
    chk("R1", "data", 32'(rd_data), 32'd0);
    chk("R1", "bit8", 32'(rd_bit8), 32'd0);
    chk("R1", "ferr", 32'(rd_ferr), 32'd0);
    chk("R1", "ovr", 32'(rd_ovr), 32'd0);
    rst_n = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);

    // R2, R6: every byte value as an 8-bit frame
    for (int v = 0; v < 256; v++) begin
      send_frame(9'(v), 1'b0, 1'b1);
      pop_expect("R2", 8'(v), 1'b0, 1'b0, 1'b0);
      expect_empty("R6");
    end

    // R2: 9-bit frames, ninth bit on rd_bit8
    nine = 1'b1;
    for (int k = 0; k < 32; k++) begin
      logic [8:0] v9;
      v9 = 9'((k * 149 + 7) % 512);
      send_frame(v9, 1'b1, 1'b1);
      pop_expect("R2", v9[7:0], v9[8], 1'b0, 1'b0);
    end
    nine = 1'b0;

    // R5: framing error then recovery
    send_frame(9'h0A5, 1'b0, 1'b0);
    pop_expect("R5", 8'hA5, 1'b0, 1'b1, 1'b0);
    send_frame(9'h03C, 1'b0, 1'b1);
    pop_expect("R5", 8'h3C, 1'b0, 1'b0, 1'b0);

    // R6, R8: queue order and overrun on the newest entry
    for (int p = 0; p < 3; p++) begin
      logic [7:0] a, b, c;
      a = 8'(p * 71 + 3); b = 8'(p * 29 + 200); c = 8'(p * 13 + 90);
      send_frame({1'b0, a}, 1'b0, 1'b1);
      send_frame({1'b0, b}, 1'b0, 1'b1);
      pop_expect("R6", a, 1'b0, 1'b0, 1'b0);
      pop_expect("R6", b, 1'b0, 1'b0, 1'b0);
      expect_empty("R6");
      send_frame({1'b0, a}, 1'b0, 1'b1);
      send_frame({1'b0, b}, 1'b0, p == 1 ? 1'b0 : 1'b1);
      send_frame({1'b0, c}, 1'b0, 1'b1);
      pop_expect("R8", a, 1'b0, 1'b0, 1'b0);
      pop_expect("R8", b, 1'b0, p == 1, 1'b1);
      expect_empty("R8");
    end

    // R9: single-buffer mode
    compat = 1'b1;
    send_frame(9'h05A, 1'b0, 1'b1);
    pop_expect("R9", 8'h5A, 1'b0, 1'b0, 1'b0);
    send_frame(9'h011, 1'b0, 1'b1);
    send_frame(9'h022, 1'b0, 1'b1);
    pop_expect("R9", 8'h11, 1'b0, 1'b0, 1'b1);
    expect_empty("R9");
    compat = 1'b0;

    // R3: disabled receiver ignores frames and a held-low line
    rx_en = 1'b0;
    send_frame(9'h055, 1'b0, 1'b1);
    expect_empty("R3");
    rxd = 1'b0;
    repeat (BIT_CLKS * 2) @(negedge clk);
    rx_en = 1'b1;
    repeat (BIT_CLKS * 2) @(negedge clk);
    hold_line(1'b1, BIT_CLKS * 2);
    expect_empty("R3");
    send_frame(9'h096, 1'b0, 1'b1);
    pop_expect("R3", 8'h96, 1'b0, 1'b0, 1'b0);

    // R4: short low pulse is rejected
    hold_line(1'b0, 6);
    hold_line(1'b1, BIT_CLKS * 2);
    expect_empty("R4");
    send_frame(9'h081, 1'b0, 1'b1);
    pop_expect("R4", 8'h81, 1'b0, 1'b0, 1'b0);

    // R7: ready while empty has no effect; head holds while not ready
    rd_ready = 1'b1;
    repeat (5) @(negedge clk);
    rd_ready = 1'b0;
    send_frame(9'h0C3, 1'b0, 1'b1);
    repeat (BIT_CLKS * 2) @(negedge clk);
    pop_expect("R7", 8'hC3, 1'b0, 1'b0, 1'b0);
    expect_empty("R7");

    finish_run();
  end
endmodule